// File: doc/BRIEF.md
# One-Bit Third-Order Sinc Decimator

This block is the first decimation stage behind a stereo one-bit sigma-delta modulator. Each channel supplies one bit per input sample. A one is read as +1 and a zero as -1. The block filters each stream with a third-order sin(x)/x response and keeps one filtered value out of every sixteen input samples. An input running at 128 times the audio sample rate therefore becomes a multi-bit stream at 8 times that rate.

The filter kernel has 64 symmetric taps. It is the convolution of three boxcars, each 22 samples long, so its DC gain is 22^3 = 10648. It is built as a cascade of three running accumulators and three difference stages. Each difference stage subtracts the value it saw 22 accepted samples earlier. A shared clock enable marks the cycles in which the input bits are valid, and a one-cycle strobe marks each new pair of output words.

Top module: `sinc3_decimator`

## Requirements
- R1: While reset is high, and in the cycle after it is released, both output words are 0 and the valid strobe is low. Reset clears all filter history, so samples taken before reset count as 0 rather than -1.
- R2: Samples are counted from reset. The valid strobe is high for exactly one cycle, namely the cycle after the clock edge that accepts the 16th, 32nd, 48th and so on sample. It is low in every other cycle.
- R3: Let n be the sample that triggers a strobe. The output word on the strobe equals the sum of h[k]*x[n-k] for k from 0 to 63, where x is +1 for a one bit and -1 for a zero bit. Here h is the 64-tap convolution of three length-22 boxcars, with h[0]=1, h[1]=3 and h[k]=h[63-k].
- R4: A cycle with the clock enable low does not advance the filter or the sample count, and its input bits have no effect on any later output.
- R5: A steady stream of ones gives +10648 and a steady stream of zeros gives -10648 once 64 samples have been taken. No output ever lies outside -10648..+10648.
- R6: The left and right channels are filtered independently. A pattern on one channel does not change the other channel's output.
- R7: Between strobes both output words hold the value they took at the last strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_in | input | 1 | High in cycles that carry a new input bit for both channels |
| bit_l | input | 1 | Left channel bit (1 = +1, 0 = -1) |
| bit_r | input | 1 | Right channel bit (1 = +1, 0 = -1) |
| smp_l | output | 15 | Left filtered word, two's complement |
| smp_r | output | 15 | Right filtered word, two's complement |
| smp_valid | output | 1 | One-cycle strobe marking new output words |

## Verification
The hardest thing to reach from the ports is a single kernel tap landing exactly on a decimation instant. The strobe only shows every 16th filtered value, and the 64-tap response is only visible through sums of ±1 inputs. To get there, the stimulus places a lone one in a stream of zeros at each of the sixteen phases relative to the strobe. This exposes every tap value as -10648 + 2*h[k]. Clock-enable gaps with random bits on the inputs, and a reset at a sample count that is not a multiple of 16, check that neither the filter history nor the strobe phase moves. The bench compares each strobe against a direct 64-term convolution that it computes itself.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;

    // Word width that holds +/- box_len^3 in two's complement.
    function automatic int acc_width(input int box_len);
        return $clog2(box_len * box_len * box_len) + 1;
    endfunction

    // Filter gain at DC: sum of all kernel taps.
    function automatic int dc_gain(input int box_len);
        return box_len * box_len * box_len;
    endfunction

    // Per-cycle phase information shared by both channels.
    typedef struct packed {
        logic accept;   // an input sample is taken this cycle
        logic emit;     // this sample closes a decimation group
    } phase_t;

endpackage

// File: rtl/sinc3_phase.sv
module sinc3_phase
    import sinc3_pkg::*;
#(
    parameter int DECIM = 16
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   ce_in,
    output phase_t ph
);
    localparam int CNT_W = (DECIM > 1) ? $clog2(DECIM) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DECIM - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (ce_in) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    always_comb begin
        ph.accept = ce_in;
        ph.emit   = ce_in && (cnt == LAST);
    end
endmodule

// File: rtl/sinc3_integ.sv
module sinc3_integ #(
    parameter int W = 15
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ce,
    input  logic                bit_in,
    output logic signed [W-1:0] acc3_next
);
    logic signed [W-1:0] step;
    logic signed [W-1:0] i1, i2, i3;
    logic signed [W-1:0] n1, n2, n3;

    always_comb begin
        step      = bit_in ? W'(1) : {W{1'b1}};
        n1        = i1 + step;
        n2        = i2 + n1;
        n3        = i3 + n2;
        acc3_next = n3;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            i1 <= '0;
            i2 <= '0;
            i3 <= '0;
        end else if (ce) begin
            i1 <= n1;
            i2 <= n2;
            i3 <= n3;
        end
    end
endmodule

// File: rtl/sinc3_comb.sv
module sinc3_comb #(
    parameter int W     = 15,
    parameter int DELAY = 22
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ce,
    input  logic signed [W-1:0] din,
    output logic signed [W-1:0] dout
);
    logic signed [W-1:0] line [DELAY];

    assign dout = din - line[DELAY-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DELAY; i++) line[i] <= '0;
        end else if (ce) begin
            line[0] <= din;
            for (int i = 1; i < DELAY; i++) line[i] <= line[i-1];
        end
    end
endmodule

// File: rtl/sinc3_decimator.sv
module sinc3_decimator
    import sinc3_pkg::*;
#(
    parameter int BOX_LEN = 22,
    parameter int DECIM   = 16,
    localparam int OUT_W  = sinc3_pkg::acc_width(BOX_LEN),
    localparam int GAIN   = sinc3_pkg::dc_gain(BOX_LEN)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ce_in,
    input  logic                    bit_l,
    input  logic                    bit_r,
    output logic signed [OUT_W-1:0] smp_l,
    output logic signed [OUT_W-1:0] smp_r,
    output logic                    smp_valid
);
    localparam int NUM_CH = 2;
    localparam int ORDER  = 3;

    phase_t ph;
    logic [NUM_CH-1:0]       bits;
    logic signed [OUT_W-1:0] res [NUM_CH];
    logic                    valid_q;

    assign bits = {bit_r, bit_l};

    sinc3_phase #(.DECIM(DECIM)) u_phase (
        .clk   (clk),
        .rst   (rst),
        .ce_in (ce_in),
        .ph    (ph)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic signed [OUT_W-1:0] chain [ORDER+1];
        logic signed [OUT_W-1:0] out_q;

        sinc3_integ #(.W(OUT_W)) u_integ (
            .clk       (clk),
            .rst       (rst),
            .ce        (ph.accept),
            .bit_in    (bits[c]),
            .acc3_next (chain[0])
        );

        for (genvar s = 0; s < ORDER; s++) begin : g_comb
            sinc3_comb #(.W(OUT_W), .DELAY(BOX_LEN)) u_comb (
                .clk  (clk),
                .rst  (rst),
                .ce   (ph.accept),
                .din  (chain[s]),
                .dout (chain[s+1])
            );
        end

        always_ff @(posedge clk) begin
            if (rst)          out_q <= '0;
            else if (ph.emit) out_q <= chain[ORDER];
        end

        assign res[c] = out_q;
    end

    always_ff @(posedge clk) begin
        if (rst) valid_q <= 1'b0;
        else     valid_q <= ph.emit;
    end

    assign smp_l     = res[0];
    assign smp_r     = res[1];
    assign smp_valid = valid_q;
endmodule

// File: rtl/sinc3_decimator_chk.sv
module sinc3_decimator_chk #(
    parameter int DECIM = 16,
    parameter int GAIN  = 10648,
    parameter int OUT_W = 15
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    ce_in,
    input logic                    smp_valid,
    input logic signed [OUT_W-1:0] smp_l,
    input logic signed [OUT_W-1:0] smp_r
);
    localparam int CNT_W = (DECIM > 1) ? $clog2(DECIM) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DECIM - 1);

    logic [CNT_W-1:0] seen;

    always_ff @(posedge clk) begin
        if (rst)        seen <= '0;
        else if (ce_in) seen <= (seen == LAST) ? '0 : seen + 1'b1;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!smp_valid && smp_l == '0 && smp_r == '0));

    // R2
    strobe_phase_chk: assert property (@(posedge clk) disable iff (rst)
        smp_valid == ($past(ce_in) && ($past(seen) == LAST)));

    // R2
    strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
        smp_valid |=> !smp_valid);

    // R5
    range_l_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(smp_l) <= GAIN) && (int'(smp_l) >= -GAIN));

    // R5
    range_r_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(smp_r) <= GAIN) && (int'(smp_r) >= -GAIN));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |-> ($stable(smp_l) && $stable(smp_r)));
endmodule

bind sinc3_decimator sinc3_decimator_chk #(
    .DECIM (DECIM),
    .GAIN  (GAIN),
    .OUT_W (OUT_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ce_in     (ce_in),
    .smp_valid (smp_valid),
    .smp_l     (smp_l),
    .smp_r     (smp_r)
);

// File: tb/test_sinc3_decimator.sv
`timescale 1ns/1ps
module test_sinc3_decimator;
    localparam int L     = 22;
    localparam int D     = 16;
    localparam int W     = 15;
    localparam int NT    = 3 * (L - 1) + 1;
    localparam int GAIN  = L * L * L;
    localparam int HMAX  = 8192;

    logic clk = 1'b0;
    logic rst, ce_in, bit_l, bit_r;
    logic signed [W-1:0] smp_l, smp_r;
    logic smp_valid;

    always #2.5 clk = ~clk;

    sinc3_decimator i_sinc3_decimator (
        .clk(clk), .rst(rst), .ce_in(ce_in), .bit_l(bit_l), .bit_r(bit_r),
        .smp_l(smp_l), .smp_r(smp_r), .smp_valid(smp_valid)
    );

    int h [NT];
    int xl [HMAX];
    int xr [HMAX];
    int n;
    int exp_l, exp_r;
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
        end
    endtask

    function automatic int model(input bit right);
        int s = 0;
        for (int k = 0; k < NT; k++) begin
            int idx = n - 1 - k;
            if (idx >= 0) s += h[k] * (right ? xr[idx] : xl[idx]);
        end
        return s;
    endfunction

    task automatic push(input bit bl, input bit br);
        ce_in = 1'b1; bit_l = bl; bit_r = br;
        xl[n] = bl ? 1 : -1;
        xr[n] = br ? 1 : -1;
        n++;
        @(negedge clk);
        ce_in = 1'b0;
        if (n % D == 0) begin
            exp_l = model(1'b0);
            exp_r = model(1'b1);
            chk(smp_valid == 1'b1, "R2 strobe", int'(smp_valid), 1);
            chk(int'(smp_l) == exp_l, "R3 left", int'(smp_l), exp_l);
            chk(int'(smp_r) == exp_r, "R3 right", int'(smp_r), exp_r);
        end else begin
            chk(smp_valid == 1'b0, "R2 no strobe", int'(smp_valid), 0);
            chk(int'(smp_l) == exp_l, "R7 hold left", int'(smp_l), exp_l);
            chk(int'(smp_r) == exp_r, "R7 hold right", int'(smp_r), exp_r);
        end
    endtask

    task automatic idle(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            ce_in = 1'b0;
            bit_l = 1'($urandom);
            bit_r = 1'($urandom);
            @(negedge clk);
            chk(smp_valid == 1'b0, "R4 idle strobe", int'(smp_valid), 0);
            chk(int'(smp_l) == exp_l, "R4 idle left", int'(smp_l), exp_l);
            chk(int'(smp_r) == exp_r, "R4 idle right", int'(smp_r), exp_r);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; ce_in = 1'b0; bit_l = 1'b1; bit_r = 1'b1;
        repeat (3) @(negedge clk);
        chk(smp_valid == 1'b0 && smp_l == '0 && smp_r == '0, "R1 in reset",
            int'(smp_l), 0);
        rst = 1'b0;
        n = 0; exp_l = 0; exp_r = 0;
        @(negedge clk);
        chk(smp_valid == 1'b0, "R1 valid after reset", int'(smp_valid), 0);
        chk(smp_l == '0 && smp_r == '0, "R1 words after reset", int'(smp_r), 0);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int t1 [2*L-1];
        for (int k = 0; k < 2*L-1; k++) begin
            t1[k] = 0;
            for (int j = 0; j < L; j++) if (k - j >= 0 && k - j < L) t1[k]++;
        end
        for (int k = 0; k < NT; k++) begin
            h[k] = 0;
            for (int j = 0; j < L; j++) if (k - j >= 0 && k - j < 2*L-1) h[k] += t1[k-j];
        end

        rst = 1'b1; ce_in = 1'b0; bit_l = 1'b0; bit_r = 1'b0;
        n = 0; exp_l = 0; exp_r = 0;
        @(negedge clk);
        do_reset();

        // R5: all ones reaches full positive scale
        for (int i = 0; i < 96; i++) push(1'b1, 1'b1);
        chk(int'(smp_l) == GAIN, "R5 ones left", int'(smp_l), GAIN);
        chk(int'(smp_r) == GAIN, "R5 ones right", int'(smp_r), GAIN);

        // R5: all zeros reaches full negative scale
        do_reset();
        for (int i = 0; i < 96; i++) push(1'b0, 1'b0);
        chk(int'(smp_l) == -GAIN, "R5 zeros left", int'(smp_l), -GAIN);
        chk(int'(smp_r) == -GAIN, "R5 zeros right", int'(smp_r), -GAIN);

        // R3: lone one at every phase against the strobe exposes each tap
        for (int p = 0; p < D; p++) begin
            for (int i = 0; i < 64 + p; i++) push(1'b0, 1'b0);
            push(1'b1, 1'b0);
            for (int i = 0; i < 79 - p; i++) push(1'b0, 1'b0);
        end

        // R6: left random, right constant ones
        do_reset();
        for (int i = 0; i < 256; i++) push(1'($urandom), 1'b1);
        chk(int'(smp_r) == GAIN, "R6 right unaffected", int'(smp_r), GAIN);

        // R4: alternating pattern with enable gaps carrying random bits
        for (int i = 0; i < 320; i++) begin
            push(1'(i & 1), 1'((i >> 1) & 1));
            if (i % 5 == 4) idle(1 + (i % 3));
        end

        // R1/R2: reset at a sample count off the decimation grid
        for (int i = 0; i < 7; i++) push(1'b1, 1'b0);
        do_reset();
        for (int i = 0; i < 32; i++) push(1'b1, 1'b0);

        // R3: random streams on both channels
        for (int i = 0; i < 1024; i++) push(1'($urandom), 1'($urandom));

        // R3: random density bursts
        for (int i = 0; i < 512; i++) push(($urandom % 8) != 0, ($urandom % 8) == 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule